// File: doc/BRIEF.md
# Flash Request Segmentation Sequencer

This block takes one long flash request (read, program or erase), described by a start address and a byte count, and carries it out as a run of cycles that a flash hardware sequencer can accept. For each segment it presents the cycle kind, address and size, pulses a start strobe, and waits for the sequencer to answer with done or error. It then moves the address forward and lowers the remaining count until nothing is left.

Data requests are cut to fit a transfer buffer of parameterised size and never cross a 256-byte page. Erase requests must be sector aligned. Each erase step picks the large block erase where it can and the small sector erase everywhere else. The block marks buffer traffic with a one-cycle strobe. A fill strobe comes before each program cycle, and a drain strobe comes after each completed read cycle. The request ends with a one-cycle finish pulse that carries one status: success, argument error, hardware error or timeout.

Top module: `flash_seg_seq`

## Requirements
- R1: A read (op 0) or program (op 1) segment has a length equal to the smallest of three values: the remaining count, BUF_BYTES, and the bytes up to the next 256-byte page boundary. The page limit applies only when the address is not already a multiple of 256.
- R2: The address of each segment equals the previous segment's address plus the previous segment's length. The first segment starts at the request address.
- R3: An erase (op 2) whose address or length is not a multiple of 4096, and any request with op 3, finishes with status 1 (argument error) and issues no cycle.
- R4: An erase step uses kind 3 with length 65536 when the address is a multiple of 65536 and at least 65536 bytes remain. Otherwise it uses kind 2 with length 4096. Read segments use kind 0 and program segments use kind 1.
- R5: When a segment answers with cyc_err, the request finishes with status 2 (hardware error) and no further cycle is issued.
- R6: For a program request, buf_fill pulses in the cycle just before each cyc_start. For a read request, buf_drain pulses once after each cyc_done and before the next cyc_start.
- R7: A request with zero length finishes with status 0 and issues no cycle.
- R8: If a segment sees neither done nor error for TIMEOUT clocks, the request finishes with status 3 (timeout). fin rises TIMEOUT+1 clocks after that segment's cyc_start.
- R9: fin is a one-cycle pulse. busy is high from the cycle after acceptance through the fin cycle and low afterwards. After reset, busy, fin and all strobes are low.
- R10: A request whose segments all answer done finishes with status 0, having issued exactly the segments needed to cover its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a request; accepted only when idle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| req_addr | input | ADDR_W | Start address in bytes |
| req_len | input | LEN_W | Length in bytes |
| busy | output | 1 | A request is in progress |
| cyc_start | output | 1 | One-cycle strobe that launches a segment |
| cyc_kind | output | 2 | 0 read, 1 program, 2 small erase, 3 large erase |
| cyc_addr | output | ADDR_W | Segment address |
| cyc_len | output | LEN_W | Segment length in bytes |
| cyc_done | input | 1 | Sequencer reports segment complete |
| cyc_err | input | 1 | Sequencer reports segment failure |
| buf_fill | output | 1 | Load the buffer for the coming program segment |
| buf_drain | output | 1 | Unload the buffer after a read segment |
| fin | output | 1 | One-cycle end-of-request pulse |
| fin_status | output | 2 | 0 ok, 1 argument, 2 hardware, 3 timeout |

## Verification
Reads and programs are started at page-aligned addresses, a few bytes short of a page boundary, and at odd offsets with lengths that leave a short tail. Together these show whether the buffer limit, the page limit and the remaining-count limit each clip the segment at the right moment. Erase requests start below a 64 KiB boundary and run past it, which shows where the switch between small and large steps happens. Misaligned erases and the invalid op must issue no cycle at all. An error injected on a middle segment, and a sequencer that never answers, show that the run stops at the right segment with the right status and after the right number of clocks.

// File: rtl/flash_seg_seq.sv
module flash_seg_seq #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int BIG_ERASE   = 65536,
  parameter int TIMEOUT     = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              cyc_start,
  output logic [1:0]        cyc_kind,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [LEN_W-1:0]  cyc_len,
  input  logic              cyc_done,
  input  logic              cyc_err,
  output logic              buf_fill,
  output logic              buf_drain,
  output logic              fin,
  output logic [1:0]        fin_status
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int SB = $clog2(SMALL_ERASE);
  localparam int BB = $clog2(BIG_ERASE);
  localparam int TW = $clog2(TIMEOUT + 1);

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ER = 2'd2;
  localparam logic [1:0] ST_OK = 2'd0, ST_ARG = 2'd1, ST_HW = 2'd2, ST_TO = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_SEG, S_FILL, S_ISSUE, S_WAIT, S_DRAIN, S_ADV
  } state_t;

  state_t             st;
  logic               fin_q;
  logic [1:0]         op;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   rem;
  logic [TW-1:0]      timer;
  logic [1:0]         status;

  logic [LEN_W-1:0]   page_left, buf_cut, data_len, seg_len;
  logic               unaligned, big_ok;

  assign unaligned = |cur_addr[PB-1:0];
  assign page_left = LEN_W'(PAGE_BYTES) - LEN_W'(cur_addr[PB-1:0]);
  assign buf_cut   = (rem < LEN_W'(BUF_BYTES)) ? rem : LEN_W'(BUF_BYTES);
  assign data_len  = (unaligned && page_left < buf_cut) ? page_left : buf_cut;
  assign big_ok    = (cur_addr[BB-1:0] == '0) && (rem >= LEN_W'(BIG_ERASE));
  assign seg_len   = (op == OP_ER) ? (big_ok ? LEN_W'(BIG_ERASE) : LEN_W'(SMALL_ERASE))
                                   : data_len;

  assign busy       = (st != S_IDLE) || fin_q;
  assign cyc_start  = (st == S_ISSUE);
  assign buf_fill   = (st == S_FILL);
  assign buf_drain  = (st == S_DRAIN);
  assign fin        = fin_q;
  assign fin_status = status;
  assign cyc_addr   = cur_addr;
  assign cyc_len    = seg_len;
  assign cyc_kind   = (op == OP_ER) ? (big_ok ? 2'd3 : 2'd2) : op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fin_q    <= 1'b0;
      op       <= OP_RD;
      cur_addr <= '0;
      rem      <= '0;
      timer    <= '0;
      status   <= ST_OK;
    end else begin
      fin_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && !fin_q) begin
          op       <= req_op;
          cur_addr <= req_addr;
          rem      <= req_len;
          st       <= S_CHK;
        end
        S_CHK: begin
          if (op == 2'd3 || (op == OP_ER && ((|cur_addr[SB-1:0]) || (|rem[SB-1:0])))) begin
            status <= ST_ARG;
            fin_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_SEG;
          end
        end
        S_SEG: begin
          if (rem == '0) begin
            status <= ST_OK;
            fin_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= (op == OP_WR) ? S_FILL : S_ISSUE;
          end
        end
        S_FILL: st <= S_ISSUE;
        S_ISSUE: begin
          timer <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (cyc_err) begin
            status <= ST_HW;
            fin_q  <= 1'b1;
            st     <= S_IDLE;
          end else if (cyc_done) begin
            st <= (op == OP_RD) ? S_DRAIN : S_ADV;
          end else if (timer == TW'(TIMEOUT - 1)) begin
            status <= ST_TO;
            fin_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_DRAIN: st <= S_ADV;
        S_ADV: begin
          cur_addr <= cur_addr + ADDR_W'(seg_len);
          rem      <= rem - seg_len;
          st       <= S_SEG;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_start, buf_fill, buf_drain, fin}));

  p_fill_then_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_fill |=> cyc_start);

  p_page_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_kind[1]) |->
      (cyc_len != '0 && cyc_len <= LEN_W'(BUF_BYTES) &&
       (LEN_W'(cyc_addr[PB-1:0]) + cyc_len) <= LEN_W'(PAGE_BYTES)));

  p_big_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_kind == 2'd3) |-> (cyc_addr[BB-1:0] == '0));

  p_err_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cyc_err) |=> (fin && fin_status == ST_HW));

  p_fin_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!fin && !cyc_start));
endmodule

// File: tb/flash_seg_seq_tb.sv
module flash_seg_seq_tb;
  localparam int TMO = 20;
  localparam int BUFB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0, req_len = '0;
  logic        busy, cyc_start, buf_fill, buf_drain, fin;
  logic [1:0]  cyc_kind, fin_status;
  logic [31:0] cyc_addr, cyc_len;
  logic        cyc_done = 1'b0, cyc_err = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_seg_seq #(.BUF_BYTES(BUFB), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .cyc_start(cyc_start),
    .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .cyc_len(cyc_len),
    .cyc_done(cyc_done), .cyc_err(cyc_err), .buf_fill(buf_fill),
    .buf_drain(buf_drain), .fin(fin), .fin_status(fin_status));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  localparam int NV = 9;
  localparam int T_OP   [NV] = '{0, 0, 0, 1, 1, 2, 2, 2, 2};
  localparam int T_ADDR [NV] = '{0, 'h100, 'h1F0, 'h3C0, 'h10, 'h1000, 0, 'h800, 0};
  localparam int T_LEN  [NV] = '{0, 200, 100, 128, 300, 'h20000, 'h10000, 'h1000, 'h1800};
  localparam int T_ST   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int T_SEG  [NV] = '{0, 4, 3, 2, 5, 17, 1, 0, 0};

  task automatic run_req(input int op, input int addr, input int len,
                         input int err_at, input int hang_at,
                         output int st, output int segs, output int gap);
    int pend = -1, fills = 0, drains = 0, start_t = 0, t = 0;
    longint m_addr = addr, m_rem = len, e_len;
    int e_kind;
    bit done = 0;
    segs = 0; st = -1; gap = -1;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = addr; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) begin
      if (i > 0) @(negedge clk);
      t++;
      cyc_done = 1'b0; cyc_err = 1'b0;
      if (pend == 0) begin
        if (segs - 1 == err_at) cyc_err = 1'b1; else cyc_done = 1'b1;
        pend = -1;
      end else if (pend > 0) pend--;
      if (buf_fill) fills++;
      if (buf_drain) begin
        drains++;
        chk(op == 0 && drains == segs, "R6", "drain after read done", drains, segs);
      end
      if (cyc_start) begin
        if (op == 2) begin
          if (m_addr % 65536 == 0 && m_rem >= 65536) begin e_kind = 3; e_len = 65536; end
          else begin e_kind = 2; e_len = 4096; end
          chk(cyc_kind == 2'(e_kind) && cyc_len == 32'(e_len), "R4", "erase step",
              cyc_len, e_len);
        end else begin
          e_len = (m_rem < BUFB) ? m_rem : BUFB;
          if (m_addr % 256 != 0 && (256 - m_addr % 256) < e_len) e_len = 256 - m_addr % 256;
          chk(cyc_len == 32'(e_len) && cyc_kind == 2'(op), "R1", "data segment length",
              cyc_len, e_len);
        end
        chk(cyc_addr == 32'(m_addr), "R2", "segment address", cyc_addr, m_addr);
        if (op == 1) chk(fills == segs + 1, "R6", "fill before program", fills, segs + 1);
        if (op == 0) chk(drains == segs, "R6", "drain before next start", drains, segs);
        m_addr += e_len; m_rem -= e_len;
        segs++;
        start_t = t;
        pend = (segs - 1 == hang_at) ? -2 : 1;
      end
      if (fin) begin
        st = fin_status;
        gap = t - start_t;
        done = 1;
      end
    end
    cyc_done = 1'b0; cyc_err = 1'b0;
    if (!done) chk(0, "R9", "request never finished", 0, 1);
    @(negedge clk);
    chk(!fin && !busy, "R9", "fin one cycle then idle", fin, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int st, segs, gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !fin && !cyc_start && !buf_fill && !buf_drain, "R9", "reset state",
        {busy, fin, cyc_start, buf_fill, buf_drain}, 0);

    for (int v = 0; v < NV; v++) begin
      run_req(T_OP[v], T_ADDR[v], T_LEN[v], -1, -1, st, segs, gap);
      // R3 R7 R10: final status and segment count per vector
      chk(st == T_ST[v], (T_ST[v] == 1) ? "R3" : (T_LEN[v] == 0 ? "R7" : "R10"),
          "final status", st, T_ST[v]);
      chk(segs == T_SEG[v], (T_ST[v] == 1) ? "R3" : "R10", "segment count", segs, T_SEG[v]);
    end

    run_req(0, 0, 256, 1, -1, st, segs, gap);
    chk(st == 2, "R5", "hw error status", st, 2);
    chk(segs == 2, "R5", "stop after failed segment", segs, 2);

    run_req(2, 'h10000, 'h20000, 0, -1, st, segs, gap);
    chk(st == 2 && segs == 1, "R5", "erase error at first step", segs, 1);

    run_req(1, 0, 128, -1, 0, st, segs, gap);
    chk(st == 3, "R8", "timeout status", st, 3);
    chk(gap == TMO + 1, "R8", "timeout latency", gap, TMO + 1);
    chk(segs == 1, "R8", "no cycle after timeout", segs, 1);

    run_req(3, 0, 64, -1, -1, st, segs, gap);
    chk(st == 1 && segs == 0, "R3", "invalid op rejected", st, 1);

    run_req(1, 'hFF, 1, -1, -1, st, segs, gap);
    chk(st == 0 && segs == 1, "R1", "single byte at page end", segs, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule